// File: doc/BRIEF.md
# Descriptor-Driven Raster Timing Generator

This block produces the horizontal and vertical timing of a video raster from three packed 32-bit descriptor words: one for the horizontal axis, one for the vertical axis, and one extension word. The extension word adds high bits to the horizontal porch and sync fields. On each axis the descriptors set the visible size, the front porch, the sync width, the back porch and the sync polarity. A pixel-clock enable advances the raster. The block drives hsync, vsync and display-enable, and it exposes the current column and line counters.

Software writes descriptors through a small write port into staging registers. The staged set is copied into the working set only in the cycle that wraps the last pixel of the last line. A frame therefore never mixes two timings. A write that lands in that same wrap cycle is held in staging and is applied one frame later.

Top module: `vid_timing_gen`

## Requirements
- R1: While reset is held, and at the first sample after it is released, col_o and line_o are 0. The working descriptors equal the reset parameters, and the outputs follow from those values.
- R2: Each line runs through four phases in this order: visible, front porch, sync, back porch. The visible width is horizontal word bits [7:0] times 8. The front porch is bits [30:24], the sync width is bits [23:16] and the back porch is bits [15:8]. col_o counts from 0 and returns to 0 after the last back-porch pixel.
- R3: hsync_o equals horizontal bit 31 during the sync phase and equals its inverse at every other column.
- R4: Lines step through the same four phases per frame. In the vertical word, the visible line count is bits [10:0], the front porch is [30:23], the sync width is [22:20] and the back porch is [19:11]. vsync_o equals bit 31 during the sync lines and its inverse otherwise. line_o advances only when col_o wraps.
- R5: de_o is high exactly when the column is in the visible phase and the line is in the visible phase.
- R6: Extension bits [3:0] become back-porch bits [11:8], and bits [7:4] become sync-width bits [11:8]. Bits [15:8] become front-porch bits [14:7], above the 7 base bits. An extension value of 0 leaves the base widths unchanged.
- R7: A front porch, sync or back porch value of 0 removes that phase. A sync width of 0 keeps that sync output at its inactive level for the whole frame.
- R8: A write takes effect at the first frame start after it. The current frame keeps its timing. A write in the cycle that wraps the frame is applied at the following frame start instead.
- R9: While pix_en_i is low, col_o, line_o and all sync and enable outputs hold their values.
- R10: Write address 0 selects the horizontal word, 1 the vertical word and 2 the extension word. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Pixel-clock enable; advances the raster |
| wr_en_i | input | 1 | Descriptor write strobe |
| wr_addr_i | input | 2 | Descriptor select |
| wr_data_i | input | 32 | Descriptor write data |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Display enable |
| col_o | output | 16 | Current column |
| line_o | output | 12 | Current line |

## Verification
The risky overlap is a descriptor write landing in the same cycle as the frame wrap. In that cycle the staging register captures the new word while the working set loads from staging. The bench places a write exactly on the final pixel of a frame. It then checks two things pixel by pixel: the next frame still runs the old timing, and only the frame after that shows the new one. A mid-frame write is checked the same way to confirm it waits for the boundary.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int WORD_W    = 32;
  localparam int ADDR_W    = 2;
  localparam int NUM_WORDS = 3;
  localparam int IDX_H     = 0;
  localparam int IDX_V     = 1;
  localparam int IDX_X     = 2;

  localparam int H_ACT_W = 11;
  localparam int H_FP_W  = 15;
  localparam int H_SW_W  = 12;
  localparam int H_BP_W  = 12;
  localparam int V_ACT_W = 11;
  localparam int V_FP_W  = 8;
  localparam int V_SW_W  = 3;
  localparam int V_BP_W  = 9;

  localparam int H_MAX = (2**H_ACT_W - 1) + (2**H_FP_W - 1) + (2**H_SW_W - 1) + (2**H_BP_W - 1);
  localparam int V_MAX = (2**V_ACT_W - 1) + (2**V_FP_W - 1) + (2**V_SW_W - 1) + (2**V_BP_W - 1);
  localparam int H_CNT_W = $clog2(H_MAX + 1);
  localparam int V_CNT_W = $clog2(V_MAX + 1);

  typedef struct packed {
    logic              pol;
    logic [H_FP_W-1:0]  fp;
    logic [H_SW_W-1:0]  sw;
    logic [H_BP_W-1:0]  bp;
    logic [H_ACT_W-1:0] act;
  } h_cfg_t;

  typedef struct packed {
    logic              pol;
    logic [V_FP_W-1:0]  fp;
    logic [V_SW_W-1:0]  sw;
    logic [V_BP_W-1:0]  bp;
    logic [V_ACT_W-1:0] act;
  } v_cfg_t;

  function automatic h_cfg_t decode_h(input logic [WORD_W-1:0] hw, input logic [15:0] xw);
    h_cfg_t d;
    d.pol = hw[31];
    d.fp  = {xw[15:8], hw[30:24]};
    d.sw  = {xw[7:4], hw[23:16]};
    d.bp  = {xw[3:0], hw[15:8]};
    d.act = {hw[7:0], 3'b000};
    return d;
  endfunction

  function automatic v_cfg_t decode_v(input logic [WORD_W-1:0] vw);
    v_cfg_t d;
    d.pol = vw[31];
    d.fp  = vw[30:23];
    d.sw  = vw[22:20];
    d.bp  = vw[19:11];
    d.act = vw[10:0];
    return d;
  endfunction
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter logic [NUM_WORDS*WORD_W-1:0] RST_VAL = '0
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               wr_en_i,
  input  logic [ADDR_W-1:0]                  wr_addr_i,
  input  logic [WORD_W-1:0]                  wr_data_i,
  input  logic                               load_i,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]   words_o
);
  logic [NUM_WORDS-1:0][WORD_W-1:0] stage_q;
  logic [NUM_WORDS-1:0][WORD_W-1:0] work_q;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[g] <= RST_VAL[g*WORD_W +: WORD_W];
        work_q[g]  <= RST_VAL[g*WORD_W +: WORD_W];
      end else begin
        if (wr_en_i && (wr_addr_i == ADDR_W'(g))) stage_q[g] <= wr_data_i;
        // working copy takes the pre-edge staging value; same-edge writes wait a frame
        if (load_i) work_q[g] <= stage_q[g];
      end
    end
  end

  assign words_o = work_q;
endmodule

// File: rtl/vtg_axis.sv
module vtg_axis #(
  parameter int CNT_W = 16,
  parameter int ACT_W = 11,
  parameter int FP_W  = 15,
  parameter int SW_W  = 12,
  parameter int BP_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             pol_i,
  input  logic [ACT_W-1:0] act_i,
  input  logic [FP_W-1:0]  fp_i,
  input  logic [SW_W-1:0]  sw_i,
  input  logic [BP_W-1:0]  bp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o,
  output logic             vis_o,
  output logic             sync_o
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] vis_end, fp_end, sw_end, tot, nxt, cur;
  logic             in_sync;

  always_comb begin
    vis_end = SUM_W'(act_i);
    fp_end  = vis_end + SUM_W'(fp_i);
    sw_end  = fp_end + SUM_W'(sw_i);
    tot     = sw_end + SUM_W'(bp_i);
    cur     = SUM_W'(cnt_q);
    nxt     = cur + SUM_W'(1);
    last_o  = nxt >= tot;
    vis_o   = cur < vis_end;
    in_sync = (cur >= fp_end) && (cur < sw_end);
    sync_o  = in_sync ? pol_i : ~pol_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (adv_i)  cnt_q <= last_o ? '0 : cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
  import vtg_pkg::*;
#(
  parameter logic [WORD_W-1:0] H_RST_WORD = 32'h8203_0402,
  parameter logic [WORD_W-1:0] V_RST_WORD = 32'h00A0_1804,
  parameter logic [WORD_W-1:0] X_RST_WORD = 32'h0000_0000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pix_en_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o,
  output logic [H_CNT_W-1:0] col_o,
  output logic [V_CNT_W-1:0] line_o
);
  localparam logic [NUM_WORDS*WORD_W-1:0] RST_VAL = {X_RST_WORD, V_RST_WORD, H_RST_WORD};

  logic [NUM_WORDS-1:0][WORD_W-1:0] words;
  h_cfg_t h_cfg;
  v_cfg_t v_cfg;
  logic   h_last, v_last, h_vis, v_vis, frame_end, v_adv;
  logic   unused_xhi;

  assign h_cfg      = decode_h(words[IDX_H], words[IDX_X][15:0]);
  assign v_cfg      = decode_v(words[IDX_V]);
  assign unused_xhi = ^words[IDX_X][WORD_W-1:16];

  assign v_adv     = pix_en_i & h_last;
  assign frame_end = v_adv & v_last;

  vtg_regs #(.RST_VAL(RST_VAL)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .load_i (frame_end),
    .words_o(words)
  );

  vtg_axis #(.CNT_W(H_CNT_W), .ACT_W(H_ACT_W), .FP_W(H_FP_W), .SW_W(H_SW_W), .BP_W(H_BP_W)) u_h (
    .clk_i, .rst_ni,
    .adv_i (pix_en_i),
    .pol_i (h_cfg.pol),
    .act_i (h_cfg.act),
    .fp_i  (h_cfg.fp),
    .sw_i  (h_cfg.sw),
    .bp_i  (h_cfg.bp),
    .cnt_o (col_o),
    .last_o(h_last),
    .vis_o (h_vis),
    .sync_o(hsync_o)
  );

  vtg_axis #(.CNT_W(V_CNT_W), .ACT_W(V_ACT_W), .FP_W(V_FP_W), .SW_W(V_SW_W), .BP_W(V_BP_W)) u_v (
    .clk_i, .rst_ni,
    .adv_i (v_adv),
    .pol_i (v_cfg.pol),
    .act_i (v_cfg.act),
    .fp_i  (v_cfg.fp),
    .sw_i  (v_cfg.sw),
    .bp_i  (v_cfg.bp),
    .cnt_o (line_o),
    .last_o(v_last),
    .vis_o (v_vis),
    .sync_o(vsync_o)
  );

  assign de_o = h_vis & v_vis;
endmodule

// File: rtl/vtg_chk.sv
module vtg_chk
  import vtg_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pix_en_i,
  input logic [H_CNT_W-1:0] col_o,
  input logic [V_CNT_W-1:0] line_o,
  input logic               de_o,
  input logic               hsync_o,
  input logic               frame_end_i,
  input h_cfg_t             h_cfg_i,
  input v_cfg_t             v_cfg_i
);
  a_r9_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en_i |=> ($stable(col_o) && $stable(line_o)));

  a_r2_col_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_en_i |=> ((col_o == H_CNT_W'($past(col_o) + 1'b1)) || (col_o == '0)));

  a_r4_line_moves_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o != $past(line_o)) |-> (col_o == '0));

  a_r8_cfg_frame_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> ($stable(h_cfg_i) && $stable(v_cfg_i)));

  a_r5_de_inside_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> ((32'(col_o) < 32'(h_cfg_i.act)) && (32'(line_o) < 32'(v_cfg_i.act))));

  a_r3_hsync_idle_in_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(col_o) < 32'(h_cfg_i.act)) |-> (hsync_o == !h_cfg_i.pol));
endmodule

bind vid_timing_gen vtg_chk u_chk (
  .clk_i, .rst_ni, .pix_en_i, .col_o, .line_o, .de_o, .hsync_o,
  .frame_end_i(frame_end),
  .h_cfg_i    (h_cfg),
  .v_cfg_i    (v_cfg)
);

// File: tb/vid_timing_gen_tb.sv
module vid_timing_gen_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        pix_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        hsync, vsync, de;
  logic [15:0] col;
  logic [11:0] line;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  vid_timing_gen u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pix_en_i(pix_en), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .hsync_o(hsync), .vsync_o(vsync),
    .de_o(de), .col_o(col), .line_o(line)
  );

  function automatic logic [31:0] hword(int p, int f, int s, int b, int c);
    return (32'(p) << 31) | (32'(f) << 24) | (32'(s) << 16) | (32'(b) << 8) | 32'(c);
  endfunction

  function automatic logic [31:0] vword(int p, int f, int s, int b, int a);
    return (32'(p) << 31) | (32'(f) << 23) | (32'(s) << 20) | (32'(b) << 11) | 32'(a);
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(string what, logic ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic write_word(int a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic sync_to_frame();
    int n = 0;
    step();
    while (!(col == 0 && line == 0) && n < 100000) begin
      step(); n++;
    end
  endtask

  // walks one full frame from (0,0), comparing every pixel to the descriptor rules
  task automatic check_frame(string tag, int hp, int hf, int hs, int hb, int hc,
                             int vp, int vf, int vs, int vb, int va,
                             int wr_at, int wa, logic [31:0] wd);
    int hact = hc * 8;
    int htot = hact + hf + hs + hb;
    int vtot = va + vf + vs + vb;
    int bad = 0;
    int idx = 0;
    for (int l = 0; l < vtot; l++) begin
      for (int c = 0; c < htot; c++) begin
        logic de_e, hs_e, vs_e;
        de_e = (c < hact) && (l < va);
        hs_e = ((c >= hact + hf) && (c < hact + hf + hs)) ? hp[0] : !hp[0];
        vs_e = ((l >= va + vf) && (l < va + vf + vs)) ? vp[0] : !vp[0];
        if (col != 16'(c) || line != 12'(l) || de != de_e || hsync != hs_e || vsync != vs_e) begin
          if (bad == 0)
            $display("FAIL %s at line %0d col %0d: actual col=%0d line=%0d de=%0b hs=%0b vs=%0b expected de=%0b hs=%0b vs=%0b",
                     tag, l, c, col, line, de, hsync, vsync, de_e, hs_e, vs_e);
          bad++;
        end
        if (idx == wr_at) begin
          wr_en = 1'b1; wr_addr = 2'(wa); wr_data = wd;
        end
        step();
        wr_en = 1'b0;
        idx++;
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    pix_en = 1'b1;
    repeat (3) step();
    check("R1 col in reset", col == 0, int'(col), 0);
    rst_ni = 1'b1;
    check("R1 line after reset", line == 0, int'(line), 0);
    check("R1 de at origin", de == 1'b1, int'(de), 1);
    check("R1 hsync idle (pos pol)", hsync == 1'b0, int'(hsync), 0);
    check("R1 vsync idle (neg pol)", vsync == 1'b1, int'(vsync), 1);
  endtask

  task automatic t_default();
    check_frame("R2 R3 R4 R5 default frame", 1, 2, 3, 4, 2, 0, 1, 2, 3, 4, -1, 0, 0);
  endtask

  task automatic t_mid_write();
    check_frame("R8 frame with mid write keeps old", 1, 2, 3, 4, 2, 0, 1, 2, 3, 4,
                7, 0, hword(0, 1, 2, 1, 1));
    check_frame("R8 R3 next frame uses new h", 0, 1, 2, 1, 1, 0, 1, 2, 3, 4, -1, 0, 0);
  endtask

  task automatic t_boundary_write();
    check_frame("R8 frame with wrap-cycle write", 0, 1, 2, 1, 1, 0, 1, 2, 3, 4,
                119, 1, vword(1, 2, 1, 1, 3));
    check_frame("R8 wrap-cycle write deferred", 0, 1, 2, 1, 1, 0, 1, 2, 3, 4, -1, 0, 0);
    check_frame("R8 R4 deferred write applied", 0, 1, 2, 1, 1, 1, 2, 1, 1, 3, -1, 0, 0);
  endtask

  task automatic t_ext();
    write_word(0, hword(1, 3, 1, 2, 1));
    write_word(2, 32'h0000_0112);
    sync_to_frame();
    check_frame("R6 extension widens h fields", 1, 131, 257, 514, 1, 1, 2, 1, 1, 3, -1, 0, 0);
    write_word(2, 32'h0);
    sync_to_frame();
    check_frame("R6 zero extension base widths", 1, 3, 1, 2, 1, 1, 2, 1, 1, 3, -1, 0, 0);
  endtask

  task automatic t_zero();
    write_word(0, hword(1, 0, 0, 0, 1));
    write_word(1, vword(0, 0, 0, 1, 2));
    sync_to_frame();
    check_frame("R7 zero porch and sync phases", 1, 0, 0, 0, 1, 0, 0, 0, 1, 2, -1, 0, 0);
  endtask

  task automatic t_stall();
    logic [15:0] c0;
    logic [11:0] l0;
    logic h0, v0, d0;
    int bad = 0;
    sync_to_frame();
    repeat (3) step();
    c0 = col; l0 = line; h0 = hsync; v0 = vsync; d0 = de;
    pix_en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step();
      if (col != c0 || line != l0 || hsync != h0 || vsync != v0 || de != d0) bad++;
    end
    check("R9 outputs held while idle", bad == 0, bad, 0);
    pix_en = 1'b1;
    step();
    check("R9 resume advances col", col == c0 + 16'd1, int'(col), int'(c0) + 1);
  endtask

  task automatic t_bad_addr();
    write_word(3, hword(0, 5, 5, 5, 3));
    sync_to_frame();
    check_frame("R10 address 3 ignored", 1, 0, 0, 0, 1, 0, 0, 0, 1, 2, -1, 0, 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_default();
    t_mid_write();
    t_boundary_write();
    t_ext();
    t_zero();
    t_stall();
    t_bad_addr();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule